// File: doc/BRIEF.md
# Port Control Register With Set and Clear Write Addresses

This block holds the control and status word for each port of a multi-port storage host controller. Software changes control bits through two write addresses inside each port's 8 KiB window. A write to the set address raises every bit that is 1 in the data. A write to the clear address lowers every bit that is 1 in the data. Any bit that is 0 in the data keeps its value. A read of the set address returns the live status word.

Some bits are configuration bits that software owns. They select interrupt write-one-to-clear mode, the 16-byte command descriptor length, multiplier resume, 32-bit activation and multiplier enable. Port reset is a level that stays asserted until software clears it. Device reset and port initialize are commands: each one starts a timed operation and clears itself when that operation finishes. The ready flag is low while such an operation is pending and rises when the operation completes. A device reset finishes only when its link is up.

Top module: `pctl_regs`

## Requirements
- R1: After reset, every port reads 0x0000_0001: port reset (bit 0) is set and all other bits are 0. port_ready and rd_data are 0.
- R2: The configuration bits are bit 3 (interrupt write-one-to-clear), bit 5 (16-byte descriptor), bit 6 (multiplier resume), bit 10 (32-bit activation) and bit 13 (multiplier enable).
  - A 1 in a set write (port offset 0x1000) raises that bit.
  - A 1 in a clear write (offset 0x1004) lowers it.
  - A 0 leaves it unchanged.
  - Bits that are not assigned always read 0.
- R3: Bit 31 (ready) is read-only. Writing it at either address has no effect.
- R4: Port reset (bit 0) is set by a set write and cleared only by a clear write. While it is set:
  - ready reads 0;
  - the configuration bits read 0;
  - set writes to the configuration bits have no effect.
- R5: When a set write at clock edge E raises port initialize (bit 2), the bit reads 1 until edge E+OPC. After edge E+OPC it reads 0 and ready (bit 31) reads 1. Ready is 0 while the operation is pending.
- R6: Device reset (bit 1) follows the same timing as port initialize, with one condition: it ends only on an edge where link_up is high. Otherwise it stays set, and ready stays 0, past the nominal count. It ends on the first edge that has link_up high.
- R7: Writing bit 1 or bit 2 at the clear address does not cancel an operation that is pending.
- R8: A set write that asserts port reset aborts a pending initialize or device reset. A set write of bit 1 or bit 2 while port reset is set, or in the same write that sets port reset, starts nothing.
- R9: Port n occupies addresses n×0x2000 to n×0x2000+0x1FFF. A write to one port leaves every other port unchanged.
- R10: A read raises rd_valid exactly one cycle after rd_en. At that time rd_data holds the addressed port's status word when the address is that port's offset 0x1000, and 0 for any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_addr | input | AW | Byte address (port index above bit 12) |
| bus_wdata | input | 32 | Write data |
| link_up | input | NP | Per-port link status, gates device-reset completion |
| rd_data | output | 32 | Read data, valid one cycle after bus_re |
| rd_valid | output | 1 | Read data strobe |
| port_ready | output | NP | Per-port ready to accept commands |
| port_in_reset | output | NP | Per-port port reset level |

## Verification
Two functions can meet in one cycle: the completion of a pending initialize, and a software write that lands on the same port's word.

- A clear write of the command bits, issued one cycle after the start, must leave the count intact. Ready must still rise exactly OPC edges after the start.
- A port-reset set write issued while initialize is pending must win. The next read must show only bit 0, with ready low.

Device-reset completion is also checked against the edge on which link_up rises. Every expected word is built by the bench from the bit positions given in the requirements.

// File: rtl/pctl_pkg.sv
package pctl_pkg;
  localparam int          WIN_BITS  = 13;
  localparam logic [12:0] OFS_SET   = 13'h1000;
  localparam logic [12:0] OFS_CLR   = 13'h1004;

  localparam int B_PRST   = 0;
  localparam int B_DRST   = 1;
  localparam int B_INIT   = 2;
  localparam int B_READY  = 31;
  localparam logic [31:0] CFG_MASK = (32'd1 << 3) | (32'd1 << 5) | (32'd1 << 6)
                                   | (32'd1 << 10) | (32'd1 << 13);

  // next value of the configuration field for one write cycle
  function automatic logic [31:0] cfg_next(input logic [31:0] cfg, input logic set_we,
                                           input logic clr_we, input logic [31:0] d);
    logic [31:0] up, dn;
    up = set_we ? (d & CFG_MASK) : 32'd0;
    dn = clr_we ? (d & CFG_MASK) : 32'd0;
    return (cfg | up) & ~dn;
  endfunction

  function automatic logic [31:0] pack_status(input logic ready, input logic prst,
                                              input logic drst, input logic init,
                                              input logic [31:0] cfg);
    logic [31:0] s;
    s = cfg & CFG_MASK;
    s[B_PRST]  = prst;
    s[B_DRST]  = drst;
    s[B_INIT]  = init;
    s[B_READY] = ready;
    return s;
  endfunction
endpackage

// File: rtl/pctl_decode.sv
module pctl_decode #(
  parameter int NP  = 2,
  parameter int PIW = 1,
  parameter int AW  = 14
) (
  input  logic [AW-1:0]  addr,
  output logic [PIW-1:0] port_idx,
  output logic           hit_set,
  output logic           hit_clr
);
  import pctl_pkg::*;
  logic in_range;

  always_comb begin
    port_idx = addr[AW-1:WIN_BITS];
    in_range = (int'(port_idx) < NP);
    hit_set  = in_range && (addr[WIN_BITS-1:0] == OFS_SET);
    hit_clr  = in_range && (addr[WIN_BITS-1:0] == OFS_CLR);
  end
endmodule

// File: rtl/pctl_port.sv
module pctl_port #(
  parameter int OPC = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_we,
  input  logic        clr_we,
  input  logic [31:0] wdata,
  input  logic        link_up,
  output logic [31:0] status,
  output logic        in_reset,
  output logic        ready_o,
  output logic        op_done
);
  import pctl_pkg::*;
  localparam int CW = $clog2(OPC + 1);

  logic          prst, drst, init, ready;
  logic [31:0]   cfg;
  logic [CW-1:0] cnt;
  logic          busy, prst_nxt, start;

  always_comb begin
    busy     = drst | init;
    op_done  = busy && (cnt == '0) && (!drst || link_up);
    prst_nxt = (prst | (set_we & wdata[B_PRST])) & ~(clr_we & wdata[B_PRST]);
    start    = set_we && (wdata[B_DRST] || wdata[B_INIT]) && !prst && !wdata[B_PRST];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prst  <= 1'b1;
      drst  <= 1'b0;
      init  <= 1'b0;
      ready <= 1'b0;
      cfg   <= '0;
      cnt   <= '0;
    end else begin
      prst <= prst_nxt;
      if (prst_nxt) begin
        drst  <= 1'b0;
        init  <= 1'b0;
        ready <= 1'b0;
        cfg   <= '0;
        cnt   <= '0;
      end else begin
        cfg <= cfg_next(cfg, set_we, clr_we, wdata);
        if (start) begin
          drst  <= drst | wdata[B_DRST];
          init  <= init | wdata[B_INIT];
          cnt   <= CW'(OPC - 1);
          ready <= 1'b0;
        end else if (op_done) begin
          drst  <= 1'b0;
          init  <= 1'b0;
          ready <= 1'b1;
        end else if (busy && cnt != '0) begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  assign status   = pack_status(ready, prst, drst, init, cfg);
  assign in_reset = prst;
  assign ready_o  = ready;
endmodule

// File: rtl/pctl_regs.sv
module pctl_regs #(
  parameter int NP  = 2,
  parameter int OPC = 8,
  localparam int PIW = (NP > 1) ? $clog2(NP) : 1,
  localparam int AW  = 13 + PIW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_we,
  input  logic          bus_re,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  input  logic [NP-1:0] link_up,
  output logic [31:0]   rd_data,
  output logic          rd_valid,
  output logic [NP-1:0] port_ready,
  output logic [NP-1:0] port_in_reset
);
  logic [PIW-1:0]       port_idx;
  logic                 hit_set, hit_clr;
  logic [NP-1:0][31:0]  status_vec;
  logic [NP-1:0]        op_done;

  pctl_decode #(.NP(NP), .PIW(PIW), .AW(AW)) u_dec (
    .addr(bus_addr), .port_idx(port_idx), .hit_set(hit_set), .hit_clr(hit_clr)
  );

  for (genvar g = 0; g < NP; g++) begin : g_port
    logic sel;
    assign sel = (port_idx == PIW'(g));
    pctl_port #(.OPC(OPC)) u_port (
      .clk(clk), .rst_n(rst_n),
      .set_we(bus_we & hit_set & sel),
      .clr_we(bus_we & hit_clr & sel),
      .wdata(bus_wdata), .link_up(link_up[g]),
      .status(status_vec[g]), .in_reset(port_in_reset[g]),
      .ready_o(port_ready[g]), .op_done(op_done[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= bus_re;
      rd_data  <= (bus_re && hit_set) ? status_vec[port_idx] : 32'd0;
    end
  end
endmodule

// File: rtl/pctl_regs_chk.sv
module pctl_regs_chk #(
  parameter int NP  = 2,
  parameter int AW  = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_we,
  input logic          bus_re,
  input logic [AW-1:0] bus_addr,
  input logic          rd_valid,
  input logic [NP-1:0] port_ready,
  input logic [NP-1:0] port_in_reset,
  input logic [NP-1:0] op_done
);
  assert_rd_latency_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_re |=> rd_valid);
  assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> !rd_valid);

  for (genvar g = 0; g < NP; g++) begin : g_chk
    logic clr_hit;
    assign clr_hit = bus_we && (bus_addr == AW'(g * 32'h2000 + 32'h1004));

    assert_no_ready_in_reset_R4: assert property (@(posedge clk) disable iff (!rst_n)
      port_in_reset[g] |-> !port_ready[g]);
    assert_reset_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (port_in_reset[g] && !clr_hit) |=> port_in_reset[g]);
    assert_ready_from_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(port_ready[g]) |-> $past(op_done[g]));
    assert_done_raises_ready_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (op_done[g] && !bus_we) |=> port_ready[g]);
  end
endmodule

bind pctl_regs pctl_regs_chk #(.NP(NP), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
  .rd_valid(rd_valid), .port_ready(port_ready), .port_in_reset(port_in_reset),
  .op_done(op_done)
);

// File: tb/test_pctl_regs.sv
module test_pctl_regs;
  localparam int NP  = 2;
  localparam int OPC = 5;
  localparam int AW  = 14;
  localparam logic [31:0] RDY = 32'h8000_0000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_we = 1'b0, bus_re = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [NP-1:0] link_up = '1;
  logic [31:0]   rd_data;
  logic          rd_valid;
  logic [NP-1:0] port_ready, port_in_reset;

  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  pctl_regs #(.NP(NP), .OPC(OPC)) i_pctl_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .link_up(link_up), .rd_data(rd_data), .rd_valid(rd_valid),
    .port_ready(port_ready), .port_in_reset(port_in_reset)
  );

  function automatic logic [31:0] expand(input int c);
    int pos [5] = '{3, 5, 6, 10, 13};
    logic [31:0] v = '0;
    for (int k = 0; k < 5; k++) if (c[k]) v[pos[k]] = 1'b1;
    return v;
  endfunction

  function automatic logic [AW-1:0] adr(input int p, input int ofs);
    return AW'(p * 32'h2000 + ofs);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge
  task automatic wr(input int p, input bit clr, input logic [31:0] d);
    bus_we = 1'b1; bus_addr = adr(p, clr ? 32'h1004 : 32'h1000); bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd_at(input int p, input int ofs, output logic [31:0] d, output logic v);
    bus_re = 1'b1; bus_addr = adr(p, ofs);
    @(negedge clk);
    bus_re = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic rd(input int p, output logic [31:0] d);
    logic v;
    rd_at(p, 32'h1000, d, v);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #1_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] d;
    logic v;
    logic [31:0] m;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check("R1 ready", 32'(port_ready), 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    for (int p = 0; p < NP; p++) begin
      rd(p, d); check("R1 status", d, 32'h1);
    end

    // R8 start ignored while in reset
    wr(0, 0, 32'h0000_246E);
    rd(0, d); check("R8 start in reset", d, 32'h1);
    check("R4 ready low in reset", 32'(port_ready[0]), 32'd0);

    // leave reset, R5 exact initialize timing
    wr(0, 1, 32'h1);
    rd(0, d); check("R4 reset cleared", d, 32'h0);
    wr(0, 0, 32'h4);
    for (int j = 1; j <= OPC + 1; j++) begin
      rd(0, d);
      check("R5 init status", d, (j <= OPC) ? 32'h4 : RDY);
      check("R5 ready pin", 32'(port_ready[0]), (j >= OPC) ? 32'd1 : 32'd0);
    end

    // R3 ready bit not writable
    wr(0, 1, RDY);
    rd(0, d); check("R3 clear ready ignored", d, RDY);

    // R2 sweep of configuration bits (port 0, ready=1)
    m = '0;
    for (int c = 0; c < 32; c++) begin
      wr(0, 0, expand(c) | 32'h0000_0090);
      m = m | expand(c);
      rd(0, d); check("R2 set", d, RDY | m);
      wr(0, 1, expand(c ^ 21) | 32'h0000_0090);
      m = m & ~expand(c ^ 21);
      rd(0, d); check("R2 clear", d, RDY | m);
      wr(0, 1, 32'h0);
      rd(0, d); check("R2 zero write", d, RDY | m);
    end

    // R9 port isolation: port 1 still in reset, write port 1 set/clear
    wr(0, 0, 32'h2468); m = 32'h2468;
    wr(1, 1, 32'h1);
    wr(1, 0, 32'h2468);
    rd(1, d); check("R9 port1 cfg", d, 32'h2468);
    rd(0, d); check("R9 port0 untouched", d, RDY | m);
    wr(1, 1, 32'h2468);
    rd(0, d); check("R9 port0 after port1 clear", d, RDY | m);

    // R3 set of ready while not ready
    rd(1, d); check("R3 port1 not ready", d, 32'h0);
    wr(1, 0, RDY);
    rd(1, d); check("R3 set ready ignored", d, 32'h0);

    // R6 device reset waits for link
    link_up[1] = 1'b0;
    wr(1, 0, 32'h2);
    for (int j = 1; j <= OPC + 3; j++) begin
      rd(1, d); check("R6 drst held", d, 32'h2);
    end
    check("R6 ready low", 32'(port_ready[1]), 32'd0);
    link_up[1] = 1'b1;
    rd(1, d); check("R6 last pending", d, 32'h2);
    rd(1, d); check("R6 drst done", d, RDY);

    // R7 clear of command bits during initialize
    wr(1, 0, 32'h4);
    wr(1, 1, 32'h6);
    for (int k = 1; k <= OPC; k++) begin
      rd(1, d); check("R7 init survives clear", d, (k < OPC) ? 32'h4 : RDY);
    end

    // R8 and R4 port reset aborts initialize and clears configuration
    wr(0, 0, 32'h4);
    wr(0, 0, 32'h1);
    rd(0, d); check("R8 abort", d, 32'h1);
    check("R4 ready pin", 32'(port_ready[0]), 32'd0);
    for (int j = 0; j < OPC + 2; j++) @(negedge clk);
    rd(0, d); check("R8 no late completion", d, 32'h1);
    wr(0, 1, 32'h1);
    rd(0, d); check("R4 cfg zeroed", d, 32'h0);

    // R8 same write sets reset and initialize
    wr(1, 0, 32'h5);
    rd(1, d); check("R8 joint write", d, 32'h1);

    // R10 read decode and latency
    rd_at(0, 32'h1004, d, v);
    check("R10 clear addr reads 0", d, 32'h0);
    check("R10 valid", 32'(v), 32'd1);
    rd_at(1, 32'h0000, d, v);
    check("R10 other addr reads 0", d, 32'h0);
    @(negedge clk);
    check("R10 valid drops", 32'(rd_valid), 32'd0);

    summary();
  end
endmodule